// File: doc/BRIEF.md
# Structured Vector Access Micro-op Sequencer

This block takes one decoded structured vector load or store, which moves data between two, three or four consecutive vector registers and memory, and breaks it into an ordered stream of micro-ops. Each micro-op leaves over a valid/ready handshake and carries its kind, the register it targets, its part index, the instruction's register count, the predicate register, the addressing-mode tag, and first, last and delayed-commit flags.

Every instruction runs in two halves. A load first fetches memory into scratch interleave registers and then spreads the scratch contents into the architectural registers. A store first packs the architectural registers into the scratch registers and then writes those scratch registers to memory. Architectural register numbers wrap from 31 back to 0. The block takes a new request only after the last micro-op of the current one has been accepted downstream.

Top module: `uop_seq_top`

## Requirements
- R1: A legal request with register count N (2, 3 or 4) yields exactly 2*N micro-ops. The first is flagged first, the final one is flagged last, and no other micro-op carries either flag.
- R2: For a load, micro-ops 0..N-1 have kind LOAD (code 0) and target scratch register 32+i. Micro-ops N..2N-1 have kind DEINTERLEAVE (code 3) and target architectural register (base+i) mod 32.
- R3: For a store, micro-ops 0..N-1 have kind INTERLEAVE (code 2) and target scratch register 32+i. Micro-ops N..2N-1 have kind STORE (code 1) and also target scratch register 32+i.
- R4: Architectural register numbers wrap modulo 32. They are 0..31 on the 6-bit register output, and scratch registers use 32..35.
- R5: Every micro-op except the last carries the delayed-commit flag. The last one does not.
- R6: Each micro-op carries its part index i (0..N-1 in each half), the count N, and the request's predicate register and addressing-mode tag unchanged.
- R7: A request whose count is not 2, 3 or 4 is consumed, req_illegal is high for exactly the one cycle after acceptance, and no micro-op is emitted.
- R8: req_ready is low from the cycle after a legal acceptance until the last micro-op has been accepted. A request held valid during that window is not taken.
- R9: While uop_valid is high and uop_ready is low, the micro-op and all of its fields hold steady.
- R10: After reset uop_valid and req_illegal are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_nregs | input | 3 | Register count |
| req_base | input | 5 | First architectural register |
| req_pred | input | 4 | Predicate register index |
| req_imm_mode | input | 1 | Addressing tag: 1 immediate, 0 register offset |
| req_illegal | output | 1 | Bad count seen on the previous accepted request |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Downstream takes micro-op |
| uop_kind | output | 2 | 0 load, 1 store, 2 interleave, 3 deinterleave |
| uop_reg | output | 6 | Target register (32+ = scratch) |
| uop_part | output | 2 | Part index |
| uop_total | output | 3 | Register count N |
| uop_first | output | 1 | First micro-op flag |
| uop_last | output | 1 | Last micro-op flag |
| uop_delay | output | 1 | Delayed-commit flag |
| uop_pred | output | 4 | Predicate register index |
| uop_imm_mode | output | 1 | Addressing tag |

## Verification
The bench targets base registers near 31 with counts of 3 and 4, where a design that forgets the wrap would emit register 32 or above for architectural parts. It stalls the downstream side with alternating and pseudo-random ready patterns. A sequencer that advanced on valid alone would skip parts, and one that recomputed fields from live inputs would change them mid-stall. It presents a second request while the first is still draining, which a design with a leaky ready would swallow. It also sends counts 0, 1, 5 and 7, where a design without the count check would emit a broken sequence or no error pulse.

// File: rtl/uop_pkg.sv
package uop_pkg;
  parameter int AREG_W   = 5;
  parameter int MIN_REGS = 2;
  parameter int MAX_REGS = 4;
  parameter int PRED_W   = 4;
  parameter int PART_W   = $clog2(MAX_REGS);
  parameter int CNT_W    = $clog2(MAX_REGS + 1);
  parameter int STEP_W   = $clog2(2 * MAX_REGS);
  parameter int TREG_W   = AREG_W + 1;

  typedef enum logic [1:0] {
    K_LOAD  = 2'd0,
    K_STORE = 2'd1,
    K_ILV   = 2'd2,
    K_DILV  = 2'd3
  } uop_kind_e;

  typedef struct packed {
    logic              is_store;
    logic [CNT_W-1:0]  nregs;
    logic [AREG_W-1:0] base;
    logic [PRED_W-1:0] pred;
    logic              imm_mode;
  } req_t;

  function automatic logic count_ok(input logic [CNT_W-1:0] n);
    return (n >= CNT_W'(MIN_REGS)) && (n <= CNT_W'(MAX_REGS));
  endfunction

  function automatic logic [TREG_W-1:0] arch_reg(input logic [AREG_W-1:0] base,
                                                 input logic [PART_W-1:0] part);
    logic [AREG_W:0] sum;
    sum = {1'b0, base} + (AREG_W+1)'(part);
    return {1'b0, sum[AREG_W-1:0]};
  endfunction

  function automatic logic [TREG_W-1:0] tmp_reg(input logic [PART_W-1:0] part);
    return {1'b1, AREG_W'(part)};
  endfunction

  function automatic logic [STEP_W-1:0] last_step(input logic [CNT_W-1:0] n);
    return STEP_W'((int'(n) << 1) - 1);
  endfunction
endpackage

// File: rtl/uop_step_ctr.sv
module uop_step_ctr
  import uop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              advance,
  input  logic [STEP_W-1:0] last_idx,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              at_last
);
  assign at_last = busy && (step == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else if (start) begin
      busy <= 1'b1;
      step <= '0;
    end else if (busy && advance) begin
      if (at_last) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/uop_field_gen.sv
module uop_field_gen
  import uop_pkg::*;
(
  input  logic              is_store,
  input  logic [CNT_W-1:0]  nregs,
  input  logic [AREG_W-1:0] base,
  input  logic [STEP_W-1:0] step,
  output uop_kind_e         kind,
  output logic [TREG_W-1:0] treg,
  output logic [PART_W-1:0] part,
  output logic              first,
  output logic              last,
  output logic              delay
);
  logic [STEP_W-1:0] n_s;
  logic              second;
  logic [STEP_W-1:0] rel;

  always_comb begin
    n_s    = STEP_W'(nregs);
    second = (step >= n_s);
    rel    = second ? (step - n_s) : step;
    part   = PART_W'(rel);
    if (is_store) kind = second ? K_STORE : K_ILV;
    else          kind = second ? K_DILV  : K_LOAD;
    treg   = (!is_store && second) ? arch_reg(base, part) : tmp_reg(part);
    first  = (step == '0);
    last   = (step == last_step(nregs));
    delay  = !last;
  end
endmodule

// File: rtl/uop_seq_top.sv
module uop_seq_top
  import uop_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_is_store,
  input  logic [CNT_W-1:0]    req_nregs,
  input  logic [AREG_W-1:0]   req_base,
  input  logic [PRED_W-1:0]   req_pred,
  input  logic                req_imm_mode,
  output logic                req_illegal,
  output logic                uop_valid,
  input  logic                uop_ready,
  output logic [1:0]          uop_kind,
  output logic [TREG_W-1:0]   uop_reg,
  output logic [PART_W-1:0]   uop_part,
  output logic [CNT_W-1:0]    uop_total,
  output logic                uop_first,
  output logic                uop_last,
  output logic                uop_delay,
  output logic [PRED_W-1:0]   uop_pred,
  output logic                uop_imm_mode
);
  req_t              cur_q;
  logic              busy;
  logic [STEP_W-1:0] step;
  logic              at_last;
  logic              req_fire;
  logic              good_fire;
  logic              bad_fire;
  logic              uop_fire;
  uop_kind_e         kind;

  assign req_ready = !busy;
  assign req_fire  = req_valid && req_ready;
  assign good_fire = req_fire && count_ok(req_nregs);
  assign bad_fire  = req_fire && !count_ok(req_nregs);
  assign uop_fire  = uop_valid && uop_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q       <= '0;
      req_illegal <= 1'b0;
    end else begin
      req_illegal <= bad_fire;
      if (good_fire)
        cur_q <= '{is_store: req_is_store, nregs: req_nregs, base: req_base,
                   pred: req_pred, imm_mode: req_imm_mode};
    end
  end

  uop_step_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (good_fire),
    .advance  (uop_ready),
    .last_idx (last_step(cur_q.nregs)),
    .busy     (busy),
    .step     (step),
    .at_last  (at_last)
  );

  uop_field_gen u_fld (
    .is_store (cur_q.is_store),
    .nregs    (cur_q.nregs),
    .base     (cur_q.base),
    .step     (step),
    .kind     (kind),
    .treg     (uop_reg),
    .part     (uop_part),
    .first    (uop_first),
    .last     (uop_last),
    .delay    (uop_delay)
  );

  assign uop_valid    = busy;
  assign uop_kind     = kind;
  assign uop_total    = cur_q.nregs;
  assign uop_pred     = cur_q.pred;
  assign uop_imm_mode = cur_q.imm_mode;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_kind) && $stable(uop_reg)
      && $stable(uop_part) && $stable(uop_first) && $stable(uop_last)));
  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> !req_ready);
  // R5
  delay_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> (uop_delay != uop_last));
  // R7
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_illegal |-> !uop_valid);
  // R1
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_fire && uop_last) |=> !uop_valid);
  // R1
  at_last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> (at_last == uop_last));
endmodule

// File: tb/sim_uop_seq_top.sv
module sim_uop_seq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_is_store = 1'b0;
  logic [2:0] req_nregs = 3'd0;
  logic [4:0] req_base = 5'd0;
  logic [3:0] req_pred = 4'd0;
  logic       req_imm_mode = 1'b0;
  logic       req_illegal;
  logic       uop_valid;
  logic       uop_ready = 1'b0;
  logic [1:0] uop_kind;
  logic [5:0] uop_reg;
  logic [1:0] uop_part;
  logic [2:0] uop_total;
  logic       uop_first, uop_last, uop_delay;
  logic [3:0] uop_pred;
  logic       uop_imm_mode;

  always #5 clk = ~clk;

  uop_seq_top u0 (.*);

  typedef struct {
    int kind; int rg; int part; int total;
    int first; int last; int delay; int pred; int imm;
  } exp_t;

  exp_t q[$];
  int   tests = 0;
  int   fails = 0;
  int   exp_ill = 0;
  int   rdy_mode = 0;
  int   cyc = 0;
  bit   done = 0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_push(input int st, input int n, input int base,
                            input int pred, input int imm);
    for (int k = 0; k < 2 * n; k++) begin
      exp_t e;
      int   i = k % n;
      bit   late = (k >= n);
      if (st != 0) e.kind = late ? 1 : 2;
      else         e.kind = late ? 3 : 0;
      e.rg    = (st == 0 && late) ? ((base + i) % 32) : (32 + i);
      e.part  = i;
      e.total = n;
      e.first = (k == 0);
      e.last  = (k == 2 * n - 1);
      e.delay = (k != 2 * n - 1);
      e.pred  = pred;
      e.imm   = imm;
      q.push_back(e);
    end
  endtask

  function automatic bit next_ready();
    case (rdy_mode)
      0: return 1'b1;
      1: return cyc[0];
      default: return lfsr[0] | lfsr[3];
    endcase
  endfunction

  // one clock: drive at negedge, compare against model, advance model after posedge
  task automatic tick(input bit v, input int st, input int n, input int base,
                      input int pred, input int imm, output bit accepted);
    bit dr, acc, pop;
    req_valid    = v;
    req_is_store = st[0];
    req_nregs    = n[2:0];
    req_base     = base[4:0];
    req_pred     = pred[3:0];
    req_imm_mode = imm[0];
    dr           = next_ready();
    uop_ready    = dr;
    #1;
    chk("R8 req_ready", req_ready, q.size() == 0);
    chk("R7 req_illegal", req_illegal, exp_ill);
    chk("R1 uop_valid", uop_valid, q.size() > 0);
    if (q.size() > 0) begin
      chk("R2/R3 kind R9", uop_kind, q[0].kind);
      chk("R4 reg R9", uop_reg, q[0].rg);
      chk("R6 part", uop_part, q[0].part);
      chk("R6 total", uop_total, q[0].total);
      chk("R1 first", uop_first, q[0].first);
      chk("R1 last", uop_last, q[0].last);
      chk("R5 delay", uop_delay, q[0].delay);
      chk("R6 pred", uop_pred, q[0].pred);
      chk("R6 imm", uop_imm_mode, q[0].imm);
    end
    acc = v && (q.size() == 0);
    pop = (q.size() > 0) && dr;
    @(posedge clk);
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (pop) void'(q.pop_front());
    exp_ill = (acc && (n < 2 || n > 4)) ? 1 : 0;
    if (acc && n >= 2 && n <= 4) model_push(st, n, base, pred, imm);
    accepted = acc;
    @(negedge clk);
  endtask

  task automatic send(input int st, input int n, input int base,
                      input int pred, input int imm);
    bit a = 0;
    while (!a) tick(1'b1, st, n, base, pred, imm, a);
  endtask

  task automatic drain();
    bit a;
    for (int g = 0; g < 4; g++) tick(1'b0, 0, 0, 0, 0, 0, a);
    while (q.size() > 0) tick(1'b0, 0, 0, 0, 0, 0, a);
    tick(1'b0, 0, 0, 0, 0, 0, a);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    #1;
    chk("R10 req_ready", req_ready, 1);
    chk("R10 uop_valid", uop_valid, 0);
    chk("R10 req_illegal", req_illegal, 0);
    drain();
    // R2 load, no stalls
    rdy_mode = 0;
    send(0, 2, 3, 5, 0); drain();
    // R3 R4 store wrapping, alternating stalls
    rdy_mode = 1;
    send(1, 3, 30, 9, 1); drain();
    // R2 R4 load of four wrapping from 29, random stalls
    rdy_mode = 2;
    send(0, 4, 29, 15, 1); drain();
    // R7 bad counts
    rdy_mode = 0;
    send(0, 5, 1, 1, 0); drain();
    send(1, 1, 1, 1, 0); drain();
    send(0, 0, 1, 1, 0); drain();
    send(1, 7, 1, 1, 1); drain();
    // R8 second request presented while the first drains
    rdy_mode = 2;
    send(1, 4, 0, 2, 0);
    send(0, 3, 31, 7, 1);
    drain();
    // R9 heavy stalls on a store of two at the top of the range
    rdy_mode = 1;
    send(1, 2, 31, 12, 0); drain();
    rdy_mode = 2;
    send(0, 2, 31, 3, 1); send(1, 4, 28, 8, 1); drain();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule